// File: doc/BRIEF.md
# Segment insertion bit scan network

This block is a reconfigurable internal scan network that sits behind a test access port. It is driven by the ordinary data-register control signals of that port: a select, capture, shift and update strobe, a test clock and an asynchronous test reset. The network is a chain of one-bit gate cells. Each gate cell is a small in-path instruction register. When a gate cell is opened, it splices a hidden sub-segment into the active path between `tdi` and `tdo`. That sub-segment can be an instrument data register or another gate cell. When the gate cell is closed, it removes that sub-segment again.

Test software opens segments by scanning a 1 into the matching gate cells and then issuing an update. The chain that results is longer from the next scan onward. Several instrument registers can therefore be reached in one scan. An instrument keeps the value last written to it after its gate is closed. A per-segment enable reports whether the segment has power or clock, and a gate cell cannot open its segment while that enable is low.

The default instance holds three top-level gate cells. The first gates a 4-bit instrument register. The second gates an 8-bit register. The third gates a nested gate cell, which in turn gates a 5-bit register.

Each cell decodes a phase from the strobes. The phases are idle (not selected), capture, shift and update. Select low always decodes as idle. Otherwise capture wins over shift, and shift wins over update.

Top module: `segnet_top`

## Requirements
- R1: Every gate cell puts exactly one bit into the active path. With every gate closed, the path from `tdi` to `tdo` is 3 bits long.
- R2: A closed gate cell bypasses its segment. Scan data goes from the cell's input through its own bit only, and the segment's contents stay the same.
- R3: Scanning a 1 into a gate cell and then updating opens its segment for the next scan. This adds 4 bits for gate A, 8 bits for gate B, and 1 bit for gate C, which is the nested gate cell.
- R4: Several gate cells can be opened in one update. The path length is then 3 plus the sum of the lengths of the segments that are open.
- R5: An instrument output changes only on an update while its segment is in the path. Once its gate is closed, the output keeps its last value through later scans, whatever data is shifted.
- R6: While `trst_n` is low, every gate is closed, every instrument output is zero and `tdo` is 0.
- R7: While `seg_en[i]` is low, segment i is out of the path and its instrument output holds. An update that tries to open that gate leaves it closed, and the gate stays closed after the enable returns. The enable bits are: bit 0 for gate A, bit 1 for gate B, bit 2 for gate C, and bit 3 for the nested gate.
- R8: On capture, each gate cell in the path loads its effective open state (1 = open), and each instrument register in the path loads its current output value. Both are then shifted out on `tdo`.
- R9: The path order is fixed. An open segment lies on the `tdi` side of its gate bit. An instrument register shifts toward `tdo`, so bit 0 leaves first and the first bit shifted in lands in the most significant bit. From `tdi` to `tdo` the order is: [A data] gate A, [B data] gate B, [[C data] nested gate] gate C.
- R10: The nested gate cell and the 5-bit register are in the path only while gate C is open. They can be updated only while gate C is open.
- R11: While `dr_sel` is low, shift, capture and update strobes have no effect: `tdo` and every output hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock. Shift and capture act on the rising edge, update on the falling edge |
| trst_n | input | 1 | Asynchronous test reset, active low |
| dr_sel | input | 1 | Network selected for the current data scan |
| dr_capture | input | 1 | Capture strobe |
| dr_shift | input | 1 | Shift strobe |
| dr_update | input | 1 | Update strobe |
| tdi | input | 1 | Scan data in |
| seg_en | input | 4 | Power/clock present, one bit per gated segment |
| tdo | output | 1 | Scan data out, driven by the last gate cell's bit |
| inst_a | output | 4 | Update value of instrument register A |
| inst_b | output | 8 | Update value of instrument register B |
| inst_c | output | 5 | Update value of instrument register C (nested) |

## Verification
Each captured bit appears on `tdo` in the shift cycle that matches its distance from `tdo`. The first shift cycle shows the bit nearest `tdo`, so the driver queues one expected bit for each shift cycle. The monitor pops that bit on the falling edge, when `tdo` has settled after the rising edge that shifted the chain. Instrument outputs and gate state change on the falling edge inside the update cycle, so the bench checks them one half cycle later, once the update strobe is dropped. A new path length takes effect from the next scan. To measure it, the bench flushes 40 zeros through the chain and then shifts in a single 1, which must appear on `tdo` exactly 40 plus the length cycles after the flush began.

// File: rtl/segnet_pkg.sv
package segnet_pkg;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_CAPTURE = 2'd1,
        PH_SHIFT   = 2'd2,
        PH_UPDATE  = 2'd3
    } dr_phase_e;

    // Strobe decode: an unselected network is always idle; capture has
    // priority over shift, shift over update.
    function automatic dr_phase_e phase_of(input logic sel, input logic cap,
                                           input logic shf, input logic upd);
        dr_phase_e ph;
        if (!sel)      ph = PH_IDLE;
        else if (cap)  ph = PH_CAPTURE;
        else if (shf)  ph = PH_SHIFT;
        else if (upd)  ph = PH_UPDATE;
        else           ph = PH_IDLE;
        return ph;
    endfunction

endpackage

// File: rtl/segnet_tdr.sv
module segnet_tdr
    import segnet_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         tck,
    input  logic         trst_n,
    input  dr_phase_e    phase,
    input  logic         sel,
    input  logic         si,
    output logic         so,
    output logic [W-1:0] value
);
    logic [W-1:0] sh_q;
    logic [W-1:0] sh_d;
    logic [W-1:0] up_q;

    // next-state of the shift stage
    always_comb begin
        sh_d = sh_q;
        if (sel) begin
            unique case (phase)
                PH_CAPTURE: sh_d = up_q;
                PH_SHIFT: begin
                    if (W > 1) sh_d = {si, sh_q[W-1:1]};
                    else       sh_d = si;
                end
                PH_IDLE, PH_UPDATE: sh_d = sh_q;
            endcase
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) sh_q <= '0;
        else         sh_q <= sh_d;
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n)                        up_q <= '0;
        else if (sel && phase == PH_UPDATE) up_q <= sh_q;
    end

    assign so    = sh_q[0];
    assign value = up_q;

endmodule

// File: rtl/segnet_sib.sv
module segnet_sib
    import segnet_pkg::*;
(
    input  logic      tck,
    input  logic      trst_n,
    input  dr_phase_e phase,
    input  logic      sel,
    input  logic      gate_en,
    input  logic      si,
    input  logic      seg_so,
    output logic      seg_si,
    output logic      seg_sel,
    output logic      so
);
    logic sh_q;
    logic sh_d;
    logic up_q;
    logic open_eff;

    assign open_eff = up_q & gate_en;

    always_comb begin
        sh_d = sh_q;
        if (sel) begin
            unique case (phase)
                PH_CAPTURE:         sh_d = open_eff;
                PH_SHIFT:           sh_d = open_eff ? seg_so : si;
                PH_IDLE, PH_UPDATE: sh_d = sh_q;
            endcase
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) sh_q <= 1'b0;
        else         sh_q <= sh_d;
    end

    // a gate with no power/clock can never be loaded open
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n)                        up_q <= 1'b0;
        else if (sel && phase == PH_UPDATE) up_q <= sh_q & gate_en;
    end

    assign seg_si  = si;
    assign seg_sel = sel & open_eff;
    assign so      = sh_q;

endmodule

// File: rtl/segnet_top.sv
module segnet_top
    import segnet_pkg::*;
#(
    parameter int A_W = 4,
    parameter int B_W = 8,
    parameter int C_W = 5,
    parameter int NSEG = 4
) (
    input  logic            tck,
    input  logic            trst_n,
    input  logic            dr_sel,
    input  logic            dr_capture,
    input  logic            dr_shift,
    input  logic            dr_update,
    input  logic            tdi,
    input  logic [NSEG-1:0] seg_en,
    output logic            tdo,
    output logic [A_W-1:0]  inst_a,
    output logic [B_W-1:0]  inst_b,
    output logic [C_W-1:0]  inst_c
);
    localparam int GA = 0;
    localparam int GB = 1;
    localparam int GC = 2;
    localparam int GN = 3;

    dr_phase_e phase;
    assign phase = phase_of(dr_sel, dr_capture, dr_shift, dr_update);

    logic a_seg_si, a_seg_sel, a_tdr_so, a_so;
    logic b_seg_si, b_seg_sel, b_tdr_so, b_so;
    logic c_seg_si, c_seg_sel;
    logic n_seg_si, n_seg_sel, n_so, c_tdr_so;

    // gate A with 4-bit instrument
    segnet_tdr #(.W(A_W)) u_tdr_a (
        .tck(tck), .trst_n(trst_n), .phase(phase), .sel(a_seg_sel),
        .si(a_seg_si), .so(a_tdr_so), .value(inst_a));
    segnet_sib u_gate_a (
        .tck(tck), .trst_n(trst_n), .phase(phase), .sel(dr_sel),
        .gate_en(seg_en[GA]), .si(tdi), .seg_so(a_tdr_so),
        .seg_si(a_seg_si), .seg_sel(a_seg_sel), .so(a_so));

    // gate B with 8-bit instrument
    segnet_tdr #(.W(B_W)) u_tdr_b (
        .tck(tck), .trst_n(trst_n), .phase(phase), .sel(b_seg_sel),
        .si(b_seg_si), .so(b_tdr_so), .value(inst_b));
    segnet_sib u_gate_b (
        .tck(tck), .trst_n(trst_n), .phase(phase), .sel(dr_sel),
        .gate_en(seg_en[GB]), .si(a_so), .seg_so(b_tdr_so),
        .seg_si(b_seg_si), .seg_sel(b_seg_sel), .so(b_so));

    // gate C holding a nested gate that holds the 5-bit instrument
    segnet_tdr #(.W(C_W)) u_tdr_c (
        .tck(tck), .trst_n(trst_n), .phase(phase), .sel(n_seg_sel),
        .si(n_seg_si), .so(c_tdr_so), .value(inst_c));
    segnet_sib u_gate_n (
        .tck(tck), .trst_n(trst_n), .phase(phase), .sel(c_seg_sel),
        .gate_en(seg_en[GN]), .si(c_seg_si), .seg_so(c_tdr_so),
        .seg_si(n_seg_si), .seg_sel(n_seg_sel), .so(n_so));
    segnet_sib u_gate_c (
        .tck(tck), .trst_n(trst_n), .phase(phase), .sel(dr_sel),
        .gate_en(seg_en[GC]), .si(b_so), .seg_so(n_so),
        .seg_si(c_seg_si), .seg_sel(c_seg_sel), .so(tdo));

endmodule

// File: rtl/segnet_chk.sv
module segnet_chk #(
    parameter int A_W = 4,
    parameter int B_W = 8,
    parameter int C_W = 5
) (
    input logic           tck,
    input logic           trst_n,
    input logic           dr_sel,
    input logic           en_b,
    input logic           tdo,
    input logic [A_W-1:0] inst_a,
    input logic [B_W-1:0] inst_b,
    input logic [C_W-1:0] inst_c,
    input logic           a_seg_sel,
    input logic           c_seg_sel,
    input logic           n_seg_sel
);
    // R11: an unselected network keeps tdo
    a_r11_idle_tdo: assert property (@(posedge tck) disable iff (!trst_n)
        !dr_sel |=> $stable(tdo));

    // R5: instrument A only moves while its segment is in the path
    a_r5_hold_closed: assert property (@(negedge tck) disable iff (!trst_n)
        !a_seg_sel |=> $stable(inst_a));

    // R7: unpowered segment B keeps its instrument value
    a_r7_gate_hold: assert property (@(negedge tck) disable iff (!trst_n)
        !en_b |=> $stable(inst_b));

    // R10: nested gate can only be selected through gate C
    a_r10_nested_parent: assert property (@(posedge tck) disable iff (!trst_n)
        n_seg_sel |-> c_seg_sel);

    // R6: reset clears instruments and scan output
    always @(posedge tck) begin
        if (!trst_n) begin
            a_r6_reset_clear: assert (inst_a == '0 && inst_b == '0 &&
                                      inst_c == '0 && tdo == 1'b0);
        end
    end

endmodule

bind segnet_top segnet_chk #(.A_W(A_W), .B_W(B_W), .C_W(C_W)) u_chk (
    .tck(tck), .trst_n(trst_n), .dr_sel(dr_sel), .en_b(seg_en[1]),
    .tdo(tdo), .inst_a(inst_a), .inst_b(inst_b), .inst_c(inst_c),
    .a_seg_sel(a_seg_sel), .c_seg_sel(c_seg_sel), .n_seg_sel(n_seg_sel));

// File: tb/segnet_top_bench.sv
module segnet_top_bench;

    logic       tck = 1'b0;
    logic       trst_n = 1'b0;
    logic       dr_sel = 1'b0, dr_capture = 1'b0, dr_shift = 1'b0, dr_update = 1'b0;
    logic       tdi = 1'b0;
    logic [3:0] seg_en = 4'hF;
    logic       tdo;
    logic [3:0] inst_a;
    logic [7:0] inst_b;
    logic [4:0] inst_c;

    always #2 tck = ~tck;

    segnet_top u_segnet_top (
        .tck(tck), .trst_n(trst_n), .dr_sel(dr_sel), .dr_capture(dr_capture),
        .dr_shift(dr_shift), .dr_update(dr_update), .tdi(tdi), .seg_en(seg_en),
        .tdo(tdo), .inst_a(inst_a), .inst_b(inst_b), .inst_c(inst_c));

    int    n_vec = 0;
    int    n_bad = 0;
    bit    finished = 1'b0;
    string cur_tag = "";

    // reference model state
    logic [3:0] m_open = 4'h0;
    logic [3:0] m_a = '0;
    logic [7:0] m_b = '0;
    logic [4:0] m_c = '0;

    logic        exp_q[$];
    logic        mon_en = 1'b0;
    logic [31:0] in_vec, ex_vec;
    int          blen;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // monitor: pops one expected readback bit per shift cycle
    always @(negedge tck) begin
        if (mon_en) begin
            logic e;
            e = exp_q.pop_front();
            check(tdo === e, cur_tag, int'(tdo), int'(e));
        end
    end

    function automatic logic eff(input int i);
        return m_open[i] & seg_en[i];
    endfunction

    task automatic put(input logic bi, input logic be);
        in_vec[blen] = bi;
        ex_vec[blen] = be;
        blen++;
    endtask

    // one full data scan: capture, shift new config, update
    task automatic do_scan(input logic [3:0] ng, input logic [3:0] na,
                           input logic [7:0] nb, input logic [4:0] nc,
                           input string tag);
        logic [3:0] o;
        o = {eff(3), eff(2), eff(1), eff(0)};
        blen = 0; in_vec = '0; ex_vec = '0;
        // position 0 is next to tdi (R9 order)
        if (o[0]) for (int i = 3; i >= 0; i--) put(na[i], m_a[i]);
        put(ng[0], o[0]);
        if (o[1]) for (int i = 7; i >= 0; i--) put(nb[i], m_b[i]);
        put(ng[1], o[1]);
        if (o[2]) begin
            if (o[3]) for (int i = 4; i >= 0; i--) put(nc[i], m_c[i]);
            put(ng[3], o[3]);
        end
        put(ng[2], o[2]);
        cur_tag = tag;
        dr_sel = 1'b1; dr_capture = 1'b1;
        @(posedge tck); #1;
        dr_capture = 1'b0; dr_shift = 1'b1; mon_en = 1'b1;
        for (int k = 0; k < blen; k++) begin
            tdi = in_vec[blen-1-k];
            exp_q.push_back(ex_vec[blen-1-k]);
            @(posedge tck); #1;
        end
        dr_shift = 1'b0; mon_en = 1'b0; dr_update = 1'b1;
        @(posedge tck); #1;
        dr_update = 1'b0; dr_sel = 1'b0;
        // model update using the pre-update path
        if (o[0]) m_a = na;
        if (o[1]) m_b = nb;
        if (o[2] && o[3]) m_c = nc;
        m_open[0] = ng[0] & seg_en[0];
        m_open[1] = ng[1] & seg_en[1];
        m_open[2] = ng[2] & seg_en[2];
        if (o[2]) m_open[3] = ng[3] & seg_en[3];
        check(inst_a === m_a, {tag, " inst_a"}, int'(inst_a), int'(m_a));
        check(inst_b === m_b, {tag, " inst_b"}, int'(inst_b), int'(m_b));
        check(inst_c === m_c, {tag, " inst_c"}, int'(inst_c), int'(m_c));
    endtask

    function automatic int model_len();
        int l = 3;
        if (eff(0)) l += 4;
        if (eff(1)) l += 8;
        if (eff(2)) begin
            l += 1;
            if (eff(3)) l += 5;
        end
        return l;
    endfunction

    // marker length probe: flush zeros, then a single 1
    task automatic measure(input int exp_len, input string tag);
        int found = -1;
        dr_sel = 1'b1; dr_shift = 1'b1;
        for (int k = 0; k < 90; k++) begin
            tdi = (k == 40);
            @(negedge tck);
            if (k >= 40 && found < 0 && tdo === 1'b1) found = k - 40;
            @(posedge tck); #1;
        end
        dr_shift = 1'b0; dr_sel = 1'b0; tdi = 1'b0;
        check(found == exp_len, {tag, " length"}, found, exp_len);
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_bad++; n_vec++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge tck);
        #1;
        // R6 reset state
        check(inst_a == 0 && inst_b == 0 && inst_c == 0, "R6 outputs", int'(inst_b), 0);
        check(tdo === 1'b0, "R6 tdo", int'(tdo), 0);
        trst_n = 1'b1;
        @(posedge tck); #1;
        measure(3, "R1 all closed");
        // R3 open A; data for A ignored while A closed (R2)
        do_scan(4'b0001, 4'hA, 8'h00, 5'h00, "R3 open A");
        measure(model_len(), "R3 A open");
        // R4 A and B together, write A
        do_scan(4'b0011, 4'h5, 8'hFF, 5'h00, "R4 open B");
        measure(model_len(), "R4 A+B");
        // R10 open C, nested still closed
        do_scan(4'b0111, 4'h9, 8'hC3, 5'h1F, "R10 open C");
        measure(model_len(), "R10 nested hidden");
        do_scan(4'b1111, 4'h9, 8'hC3, 5'h00, "R10 open nested");
        measure(model_len(), "R4 full path");
        // R9 ordering checked through distinct values
        do_scan(4'b1111, 4'h6, 8'h1D, 5'h16, "R9 write all");
        do_scan(4'b1111, 4'h6, 8'h1D, 5'h16, "R8 readback");
        // R5 close A, then scan with junk aimed at A's old place
        do_scan(4'b1110, 4'h3, 8'h1D, 5'h16, "R5 close A");
        do_scan(4'b1110, 4'hC, 8'hA5, 5'h09, "R5 A held");
        measure(model_len(), "R2 A bypassed");
        // R7 drop B's enable while open
        seg_en[1] = 1'b0;
        #1;
        measure(model_len(), "R7 B gated");
        do_scan(4'b1110, 4'h0, 8'h77, 5'h09, "R7 open blocked");
        check(inst_b === 8'hA5, "R7 inst_b held", int'(inst_b), 8'hA5);
        seg_en[1] = 1'b1;
        #1;
        measure(model_len(), "R7 stays closed");
        // R11 strobes without select
        begin
            logic t0;
            t0 = tdo;
            dr_shift = 1'b1; dr_capture = 1'b0; tdi = 1'b1;
            repeat (4) @(posedge tck);
            #1;
            dr_update = 1'b1;
            @(posedge tck); #1;
            dr_update = 1'b0; dr_shift = 1'b0; tdi = 1'b0;
            check(tdo === t0, "R11 tdo", int'(tdo), int'(t0));
            check(inst_c === m_c && inst_b === m_b, "R11 outputs", int'(inst_c), int'(m_c));
        end
        measure(model_len(), "R11 path");
        // R6 reset from an open configuration
        trst_n = 1'b0;
        @(posedge tck); #1;
        m_open = '0; m_a = '0; m_b = '0; m_c = '0;
        check(inst_a == 0 && inst_b == 0 && inst_c == 0, "R6 clear", int'(inst_c), 0);
        trst_n = 1'b1;
        @(posedge tck); #1;
        measure(3, "R6 closed after reset");
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule